// File: doc/BRIEF.md
# Serial Port Status Flags and Interrupt Requests

This block keeps the status byte of a serial port. A receive engine reports frame completion and line errors as single-cycle pulses, a transmit engine reports the moment its holding byte moves into the output shifter, and the bus side reports strobes for reading received data, writing transmit data, and writing an error-clear control bit. From these events the block keeps three sticky error flags, a receive-full flag and a transmit-empty flag. It also drives a data-valid indication and two interrupt request lines.

The receive side is a two-state machine. RX_EMPTY moves to RX_HELD on a frame completion. RX_HELD moves back to RX_EMPTY on a data read that has no completion in the same cycle. RX_HELD stays in RX_HELD on a completion, and that transition counts as an overrun. The transmit side is also a two-state machine. TX_VACANT moves to TX_LOADED on a data write that has no shifter load in the same cycle. TX_LOADED moves back to TX_VACANT on a shifter load. Each error flag is a sticky bit. It is set by its own event and dropped only by a write of zero to the clear bit.

Top module: `uart_stat_core`

## Requirements
- R1: The status byte carries parity error at bit 7, overrun at bit 6, framing error at bit 5, receive-full at bit 4 and transmit-empty at bit 3. Bits 2..0 always read 0.
- R2: After reset the status byte is 8'h08, tx_irq_o is 1, and rx_irq_o and data_ok_o are 0.
- R3: A pulse on rx_par_err_i sets the parity flag at the next clock edge. A pulse on rx_frm_err_i sets the framing flag at the next clock edge.
- R4: The overrun flag is set at the next edge by a pulse on rx_ovr_i, or by rx_done_i while receive-full is already 1.
- R5: Error flags stay set through data reads, through any status activity, and through a clear-bit write whose value is 1.
- R6: When clr_wr_i is high and clr_bit_i is 0, all three error flags clear at the next edge. A set event for a flag in the same cycle keeps that flag set.
- R7: rx_done_i sets receive-full and rd_data_i clears it. When both arrive in one cycle, receive-full stays 1.
- R8: wr_data_i clears transmit-empty and tx_load_i sets it. When both arrive in one cycle, transmit-empty is 1.
- R9: data_ok_o is 1 only while receive-full is 1 and no error flag is set.
- R10: rx_irq_o is 1 exactly when rx_ie_i is 1 and at least one of the parity, overrun, framing or receive-full flags is set.
- R11: tx_irq_o equals transmit-empty at all times and does not depend on any enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done_i | input | 1 | Received byte loaded into the receive data register |
| rx_par_err_i | input | 1 | Parity error detected |
| rx_frm_err_i | input | 1 | Framing error detected |
| rx_ovr_i | input | 1 | Overrun reported by the receive engine |
| rd_data_i | input | 1 | Bus read of the receive data register |
| wr_data_i | input | 1 | Bus write of the transmit data register |
| tx_load_i | input | 1 | Holding byte moved into the transmit shifter |
| clr_wr_i | input | 1 | Write strobe for the control register that holds the clear bit |
| clr_bit_i | input | 1 | Value written to the clear bit |
| rx_ie_i | input | 1 | Receive interrupt enable |
| status_o | output | 8 | Status byte |
| data_ok_o | output | 1 | Received data is valid |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_irq_o | output | 1 | Transmit interrupt request |

## Verification
The hardest cases to reach are the ones where a set event and a clear event hit the same flag in one cycle. Examples are a zero written to the clear bit while an error pulse arrives, or a frame completing in the cycle receive-full is read. The bench therefore applies all 1024 combinations of the ten event and enable inputs, one per cycle, in two different permutations, so that every combination arrives from many different flag states. After each cycle it compares every output against a bench-side model built from the requirements. Directed sequences then cover the clear-bit value of 1 and the per-flag precedence on clearing.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
    localparam int STAT_W    = 8;
    localparam int N_ERR     = 3;
    // error vector order: [2]=parity, [1]=overrun, [0]=framing
    localparam int BIT_PAR   = 7;
    localparam int BIT_OVR   = 6;
    localparam int BIT_FRM   = 5;
    localparam int BIT_FULL  = 4;
    localparam int BIT_EMPTY = 3;
    localparam int UNUSED_W  = BIT_EMPTY;

    typedef enum logic {RX_EMPTY = 1'b0, RX_HELD = 1'b1} rx_state_t;
    typedef enum logic {TX_VACANT = 1'b0, TX_LOADED = 1'b1} tx_state_t;
endpackage

// File: rtl/uart_rx_track.sv
module uart_rx_track
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic rd_i,
    output logic full_o,
    output logic overrun_o
);
    rx_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        overrun_o = 1'b0;
        unique case (state_q)
            RX_EMPTY: if (done_i) state_d = RX_HELD;
            RX_HELD: begin
                if (done_i)    overrun_o = 1'b1;
                else if (rd_i) state_d   = RX_EMPTY;
            end
            default: state_d = RX_EMPTY;
        endcase
    end

    assign full_o = (state_q == RX_HELD);
endmodule

// File: rtl/uart_tx_track.sv
module uart_tx_track
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic load_i,
    output logic empty_o
);
    tx_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_VACANT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_VACANT: if (wr_i && !load_i) state_d = TX_LOADED;
            TX_LOADED: if (load_i)          state_d = TX_VACANT;
            default:   state_d = TX_VACANT;
        endcase
    end

    assign empty_o = (state_q == TX_VACANT);
endmodule

// File: rtl/uart_err_flags.sv
module uart_err_flags
    import uart_stat_pkg::*;
#(
    parameter int NUM = N_ERR
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic           clr_i,
    output logic [NUM-1:0] flag_o
);
    for (genvar g = 0; g < NUM; g++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[g]) q <= 1'b1;
            else if (clr_i)    q <= 1'b0;
        end
        assign flag_o[g] = q;
    end
endmodule

// File: rtl/uart_stat_core.sv
module uart_stat_core
    import uart_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done_i,
    input  logic              rx_par_err_i,
    input  logic              rx_frm_err_i,
    input  logic              rx_ovr_i,
    input  logic              rd_data_i,
    input  logic              wr_data_i,
    input  logic              tx_load_i,
    input  logic              clr_wr_i,
    input  logic              clr_bit_i,
    input  logic              rx_ie_i,
    output logic [STAT_W-1:0] status_o,
    output logic              data_ok_o,
    output logic              rx_irq_o,
    output logic              tx_irq_o
);
    logic             full, empty, ovr_det, err_clr;
    logic [N_ERR-1:0] err_set, err;

    uart_rx_track u_rx (
        .clk(clk), .rst_n(rst_n), .done_i(rx_done_i), .rd_i(rd_data_i),
        .full_o(full), .overrun_o(ovr_det)
    );

    uart_tx_track u_tx (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_data_i), .load_i(tx_load_i),
        .empty_o(empty)
    );

    assign err_set = {rx_par_err_i, rx_ovr_i | ovr_det, rx_frm_err_i};
    assign err_clr = clr_wr_i & ~clr_bit_i;

    uart_err_flags #(.NUM(N_ERR)) u_err (
        .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr),
        .flag_o(err)
    );

    always_comb begin
        status_o            = '0;
        status_o[BIT_PAR]   = err[2];
        status_o[BIT_OVR]   = err[1];
        status_o[BIT_FRM]   = err[0];
        status_o[BIT_FULL]  = full;
        status_o[BIT_EMPTY] = empty;
        data_ok_o           = full & ~(|err);
        rx_irq_o            = rx_ie_i & (full | (|err));
        tx_irq_o            = empty;
    end
endmodule

// File: rtl/uart_stat_chk.sv
module uart_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_done_i,
    input logic       rx_par_err_i,
    input logic       rx_frm_err_i,
    input logic       rx_ovr_i,
    input logic       rd_data_i,
    input logic       wr_data_i,
    input logic       tx_load_i,
    input logic       clr_wr_i,
    input logic       clr_bit_i,
    input logic       rx_ie_i,
    input logic [7:0] status_o,
    input logic       data_ok_o,
    input logic       rx_irq_o,
    input logic       tx_irq_o
);
    assert_par_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_par_err_i |=> status_o[7]);
    assert_ovr_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && status_o[4]) |=> status_o[6]);
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7:5] != 3'b000 && !(clr_wr_i && !clr_bit_i)) |=>
            status_o[7:5] == $past(status_o[7:5]) | (status_o[7:5] & ~$past(status_o[7:5])));
    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && !clr_bit_i && !rx_par_err_i && !rx_frm_err_i && !rx_ovr_i && !rx_done_i)
            |=> status_o[7:5] == 3'b000);
    assert_full_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_i |=> status_o[4]);
    assert_empty_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_i |=> status_o[3]);
    assert_valid_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7:5] != 3'b000) |-> !data_ok_o);
    assert_rx_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie_i && status_o[7:4] != 4'b0000) |-> rx_irq_o);
endmodule

bind uart_stat_core uart_stat_chk u_chk (.*);

// File: tb/sim_uart_stat_core.sv
`timescale 1ns/1ps
module sim_uart_stat_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done, par, frm, ovr, rd, wr, ld, cw, cb, ie;
    logic [7:0] st;
    logic ok, rxi, txi;
    int n_cmp = 0;
    int n_bad = 0;
    bit m_par, m_ovr, m_frm, m_full, m_empty;

    always #5 clk = ~clk;

    uart_stat_core u0 (
        .clk(clk), .rst_n(rst_n), .rx_done_i(done), .rx_par_err_i(par),
        .rx_frm_err_i(frm), .rx_ovr_i(ovr), .rd_data_i(rd), .wr_data_i(wr),
        .tx_load_i(ld), .clr_wr_i(cw), .clr_bit_i(cb), .rx_ie_i(ie),
        .status_o(st), .data_ok_o(ok), .rx_irq_o(rxi), .tx_irq_o(txi)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        {done, par, frm, ovr, rd, wr, ld, cw, cb} = '0;
    endtask

    // model step per R3, R4, R6, R7, R8
    task automatic model_step();
        bit clrz;
        clrz    = cw & ~cb;
        m_ovr   = ovr | (done & m_full) | (m_ovr & ~clrz);
        m_par   = par | (m_par & ~clrz);
        m_frm   = frm | (m_frm & ~clrz);
        m_full  = done | (m_full & ~rd);
        m_empty = ld | (m_empty & ~wr);
    endtask

    task automatic compare_all();
        chk("R3 parity",   {7'd0, st[7]}, {7'd0, m_par});
        chk("R4 overrun",  {7'd0, st[6]}, {7'd0, m_ovr});
        chk("R3 framing",  {7'd0, st[5]}, {7'd0, m_frm});
        chk("R7 full",     {7'd0, st[4]}, {7'd0, m_full});
        chk("R8 empty",    {7'd0, st[3]}, {7'd0, m_empty});
        chk("R1 unused",   {5'd0, st[2:0]}, 8'd0);
        chk("R9 data_ok",  {7'd0, ok}, {7'd0, m_full & ~(m_par | m_ovr | m_frm)});
        chk("R10 rx_irq",  {7'd0, rxi}, {7'd0, ie & (m_full | m_par | m_ovr | m_frm)});
        chk("R11 tx_irq",  {7'd0, txi}, {7'd0, m_empty});
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        #2;
        compare_all();
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle();
        ie = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        chk("R2 status", st, 8'h08);
        chk("R2 irq/ok", {5'd0, txi, rxi, ok}, 8'b100);
        m_par = 0; m_ovr = 0; m_frm = 0; m_full = 0; m_empty = 1;

        // exhaustive sweeps over all input combinations, two orders
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 1024; v++) begin
                logic [9:0] p;
                p = (pass == 0) ? v[9:0] : 10'((v * 397 + 11) % 1024);
                {done, par, frm, ovr, rd, wr, ld, cw, cb, ie} = p;
                step();
            end
        end

        // directed: R5 stickiness
        idle(); ie = 1'b1;
        cw = 1; cb = 0; step();          // clear everything
        idle(); par = 1; step();
        idle(); rd = 1; step();
        idle(); cw = 1; cb = 1; step();
        idle(); step();
        chk("R5 sticky parity", {7'd0, st[7]}, 8'd1);
        // R6: clear with framing pulse same cycle keeps framing only
        idle(); ovr = 1; step();
        idle(); cw = 1; cb = 0; frm = 1; step();
        chk("R6 clear with set", st & 8'hE0, 8'h20);
        idle(); cw = 1; cb = 0; step();
        chk("R6 clear all", st & 8'hE0, 8'h00);
        // R7 read+done same cycle
        idle(); done = 1; step();
        idle(); done = 1; rd = 1; step();
        chk("R7 full kept", {7'd0, st[4]}, 8'd1);
        chk("R4 overrun from done", {7'd0, st[6]}, 8'd1);
        // R8 write+load same cycle
        idle(); wr = 1; ld = 1; step();
        chk("R8 empty wins", {7'd0, st[3]}, 8'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule